// File: doc/BRIEF.md
# Branch Target and Mode-Switch Unit

This unit resolves control flow for a core that runs either a 32-bit native instruction set or a 16-bit compressed one. A decoder hands it one instruction per cycle: a small kind code, the raw offset fields, the half-select flag of the long call pair, a register operand, the pipeline PC and the current link register value. In the same cycle it returns the redirect target, a link-register write and, for a software interrupt, the values to save and the new status word. The only state it holds is the instruction-set mode bit. That bit changes on the clock edge after an exchange branch or a software interrupt.

The pipeline PC input is the address of the current instruction plus 4. The sequential (fall-through) address is therefore `pc_i - 2` in compressed mode and `pc_i - 4` in native mode. A long call in compressed mode takes two instructions. The first one parks a partial target in the link register. The second one adds the low offset to that value and jumps.

Top module: `brmode_unit`

## Requirements
- R1: After reset, `mode_o` is 0, which selects native execution.
- R2: Kind 1 (conditional) with `cond_ok_i`=1 loads PC with `pc_i` + (sign-extended `off8_i` << 1). Kind 2 (unconditional) loads PC with `pc_i` + (sign-extended `off11_i` << 1). Neither kind writes LR.
- R3: A kind 1 instruction with `cond_ok_i`=0 raises neither `pc_load_o` nor `lr_we_o`, and leaves the mode unchanged. `pc_next_o` then shows the sequential address.
- R4: Kind 3 with `h_i`=0 writes LR = `pc_i` + (sign-extended `off11_i` << 12), and PC is not loaded.
- R5: Kind 3 with `h_i`=1 loads PC with `lr_i` + (zero-extended `off11_i` << 1) and writes LR = `pc_i` - 1. That LR value is the second instruction's address plus 3, with bit 0 marking a compressed-mode return.
- R6: Kind 4 (register exchange) loads PC with `rm_i` with bit 0 cleared. On the next clock edge `mode_o` takes `rm_i[0]`. LR is not written.
- R7: Kind 5 (register exchange with link) behaves as kind 4. It also writes LR with the sequential address, with bit 0 set when the current mode is compressed.
- R8: Kind 6 (software interrupt) raises `swi_req_o` and loads PC with 0x08. It presents the sequential address as the saved LR and `status_i` as the saved status. The new status has bit 7 (IRQ mask) set, bit 5 (mode bit) cleared and bits 4:0 = 5'b10011 (supervisor). `mode_o` becomes 0 on the next edge.
- R9: With `valid_i`=0, or with kind 0 or 7, no PC load, no LR write and no interrupt request occur, and `mode_o` is held.
- R10: Across the two halves of a long call, the 22-bit halfword offset reaches its most negative value, -4 MiB, when `off11_i`=0x400 in the first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| kind_i | input | 3 | 0 none, 1 cond, 2 uncond, 3 long-call half, 4 exchange, 5 exchange+link, 6 software interrupt |
| cond_ok_i | input | 1 | Condition of a kind 1 branch passed |
| off8_i | input | 8 | Short conditional offset |
| off11_i | input | 11 | Unconditional / long-call offset |
| h_i | input | 1 | Long-call half select |
| rm_i | input | 32 | Register operand of exchange branches |
| pc_i | input | 32 | Pipeline PC (instruction address + 4) |
| lr_i | input | 32 | Current link register |
| status_i | input | 32 | Current status word |
| pc_next_o | output | 32 | Redirect target, or sequential address |
| pc_load_o | output | 1 | Redirect taken |
| lr_we_o | output | 1 | Link register write |
| lr_val_o | output | 32 | Link register value |
| mode_o | output | 1 | Instruction-set mode (1 = compressed) |
| swi_req_o | output | 1 | Software-interrupt entry |
| swi_lr_o | output | 32 | Return address saved to the supervisor LR |
| swi_spsr_o | output | 32 | Status saved for the interrupt |
| swi_status_o | output | 32 | Status word after entry |

## Verification
Short branches are driven with the largest positive and most negative offsets, so a lost sign extension or a missing shift gives a visibly wrong target. A long call pair is run once with an ordinary offset and once at the -4 MiB end of its range, which separates the two shift amounts and the zero-extension of the second half. Exchange branches use both odd and even operands, from both modes, which shows that the mode bit comes from bit 0 and that the link value tracks the mode. A failed condition, an idle cycle with an odd operand present, and reserved kind 7 confirm that nothing redirects or switches.

// File: rtl/brm_pkg.sv
package brm_pkg;
  typedef enum logic [2:0] {
    BK_NONE   = 3'd0,
    BK_BCOND  = 3'd1,
    BK_BUNC   = 3'd2,
    BK_BLPAIR = 3'd3,
    BK_BX     = 3'd4,
    BK_BLX    = 3'd5,
    BK_SWI    = 3'd6,
    BK_RSVD   = 3'd7
  } br_kind_e;
endpackage

// File: rtl/brm_target.sv
module brm_target
  import brm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFS_S = 8,
  parameter int OFS_L = 11,
  parameter logic [XLEN-1:0] SWI_VEC = 'h8
) (
  input  logic            valid,
  input  br_kind_e        kind,
  input  logic            cond_ok,
  input  logic            h,
  input  logic [OFS_S-1:0] off_s,
  input  logic [OFS_L-1:0] off_l,
  input  logic [XLEN-1:0] rm,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] lr,
  input  logic [XLEN-1:0] seq,
  output logic [XLEN-1:0] pc_next,
  output logic            pc_load
);
  localparam int PAD_S = XLEN - OFS_S - 1;
  localparam int PAD_L = XLEN - OFS_L - 1;

  logic [XLEN-1:0] sx_s, sx_l, zx_l;
  assign sx_s = {{PAD_S{off_s[OFS_S-1]}}, off_s, 1'b0};
  assign sx_l = {{PAD_L{off_l[OFS_L-1]}}, off_l, 1'b0};
  assign zx_l = {{PAD_L{1'b0}}, off_l, 1'b0};

  always_comb begin
    pc_next = seq;
    pc_load = 1'b0;
    if (valid) begin
      unique case (kind)
        BK_BCOND: if (cond_ok) begin
          pc_next = pc + sx_s;
          pc_load = 1'b1;
        end
        BK_BUNC: begin
          pc_next = pc + sx_l;
          pc_load = 1'b1;
        end
        BK_BLPAIR: if (h) begin
          pc_next = lr + zx_l;
          pc_load = 1'b1;
        end
        BK_BX, BK_BLX: begin
          pc_next = {rm[XLEN-1:1], 1'b0};
          pc_load = 1'b1;
        end
        BK_SWI: begin
          pc_next = SWI_VEC;
          pc_load = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/brm_link.sv
module brm_link
  import brm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFS_L = 11,
  parameter int HI_SH = 12
) (
  input  logic            valid,
  input  br_kind_e        kind,
  input  logic            h,
  input  logic            mode,
  input  logic [OFS_L-1:0] off_l,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] seq,
  output logic            lr_we,
  output logic [XLEN-1:0] lr_val
);
  localparam int PAD_H = XLEN - OFS_L - HI_SH;
  localparam logic [XLEN-1:0] K_ONE = XLEN'(1);

  logic [XLEN-1:0] hi_ofs;
  assign hi_ofs = {{PAD_H{off_l[OFS_L-1]}}, off_l, {HI_SH{1'b0}}};

  always_comb begin
    lr_we  = 1'b0;
    lr_val = seq;
    if (valid) begin
      unique case (kind)
        BK_BLPAIR: begin
          lr_we  = 1'b1;
          lr_val = h ? (pc - K_ONE) : (pc + hi_ofs);
        end
        BK_BLX: begin
          lr_we  = 1'b1;
          lr_val = {seq[XLEN-1:1], seq[0] | mode};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/brm_swi.sv
module brm_swi
  import brm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int T_POS = 5,
  parameter int I_POS = 7,
  parameter int MW = 5,
  parameter logic [MW-1:0] SVC = 5'b10011
) (
  input  logic            valid,
  input  br_kind_e        kind,
  input  logic [XLEN-1:0] status,
  input  logic [XLEN-1:0] seq,
  output logic            req,
  output logic [XLEN-1:0] saved_lr,
  output logic [XLEN-1:0] saved_st,
  output logic [XLEN-1:0] new_st
);
  assign req      = valid && (kind == BK_SWI);
  assign saved_lr = seq;
  assign saved_st = status;

  for (genvar b = 0; b < XLEN; b++) begin : g_st
    if (b < MW) begin : g_mode
      assign new_st[b] = SVC[b];
    end else if (b == T_POS) begin : g_t
      assign new_st[b] = 1'b0;
    end else if (b == I_POS) begin : g_i
      assign new_st[b] = 1'b1;
    end else begin : g_keep
      assign new_st[b] = status[b];
    end
  end
endmodule

// File: rtl/brm_mode_reg.sv
module brm_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic rs_meta, rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_q    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_q    <= rs_meta;
    end
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/brmode_unit.sv
module brmode_unit
  import brm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFS_S = 8,
  parameter int OFS_L = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [2:0]       kind_i,
  input  logic             cond_ok_i,
  input  logic [OFS_S-1:0] off8_i,
  input  logic [OFS_L-1:0] off11_i,
  input  logic             h_i,
  input  logic [XLEN-1:0]  rm_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  lr_i,
  input  logic [XLEN-1:0]  status_i,
  output logic [XLEN-1:0]  pc_next_o,
  output logic             pc_load_o,
  output logic             lr_we_o,
  output logic [XLEN-1:0]  lr_val_o,
  output logic             mode_o,
  output logic             swi_req_o,
  output logic [XLEN-1:0]  swi_lr_o,
  output logic [XLEN-1:0]  swi_spsr_o,
  output logic [XLEN-1:0]  swi_status_o
);
  localparam logic [XLEN-1:0] STEP_C = XLEN'(2);
  localparam logic [XLEN-1:0] STEP_N = XLEN'(4);

  br_kind_e        kind;
  logic [XLEN-1:0] seq;
  logic            mode_en, mode_d;

  assign kind = br_kind_e'(kind_i);
  assign seq  = pc_i - (mode_o ? STEP_C : STEP_N);

  always_comb begin
    mode_en = valid_i && (kind == BK_BX || kind == BK_BLX || kind == BK_SWI);
    mode_d  = (kind == BK_SWI) ? 1'b0 : rm_i[0];
  end

  brm_target #(.XLEN(XLEN), .OFS_S(OFS_S), .OFS_L(OFS_L)) u_target (
    .valid(valid_i), .kind(kind), .cond_ok(cond_ok_i), .h(h_i),
    .off_s(off8_i), .off_l(off11_i), .rm(rm_i), .pc(pc_i), .lr(lr_i),
    .seq(seq), .pc_next(pc_next_o), .pc_load(pc_load_o)
  );

  brm_link #(.XLEN(XLEN), .OFS_L(OFS_L)) u_link (
    .valid(valid_i), .kind(kind), .h(h_i), .mode(mode_o), .off_l(off11_i),
    .pc(pc_i), .seq(seq), .lr_we(lr_we_o), .lr_val(lr_val_o)
  );

  brm_swi #(.XLEN(XLEN)) u_swi (
    .valid(valid_i), .kind(kind), .status(status_i), .seq(seq),
    .req(swi_req_o), .saved_lr(swi_lr_o), .saved_st(swi_spsr_o),
    .new_st(swi_status_o)
  );

  brm_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .en(mode_en), .d(mode_d), .q(mode_o)
  );
endmodule

// File: rtl/brm_chk.sv
module brm_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [2:0]      kind_i,
  input logic            cond_ok_i,
  input logic [XLEN-1:0] rm_i,
  input logic [XLEN-1:0] pc_next_o,
  input logic            pc_load_o,
  input logic            lr_we_o,
  input logic            mode_o,
  input logic            swi_req_o,
  input logic [XLEN-1:0] swi_status_o
);
  // R3
  cond_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 3'd1 && !cond_ok_i) |-> (!pc_load_o && !lr_we_o));

  // R6
  bx_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 3'd4) |-> (pc_load_o && !pc_next_o[0] && !lr_we_o));

  // R6
  bx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 3'd4) |=> (mode_o == $past(rm_i[0])));

  // R8
  swi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_req_o |-> (pc_next_o == XLEN'(8) && !swi_status_o[5] && swi_status_o[7]));

  // R8
  swi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_req_o |=> !mode_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(mode_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!pc_load_o && !lr_we_o && !swi_req_o));
endmodule

bind brmode_unit brm_chk #(.XLEN(XLEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
  .cond_ok_i(cond_ok_i), .rm_i(rm_i), .pc_next_o(pc_next_o),
  .pc_load_o(pc_load_o), .lr_we_o(lr_we_o), .mode_o(mode_o),
  .swi_req_o(swi_req_o), .swi_status_o(swi_status_o)
);

// File: tb/test_brmode_unit.sv
`timescale 1ns/1ps
module test_brmode_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, cond_ok_i, h_i;
  logic [2:0]  kind_i;
  logic [7:0]  off8_i;
  logic [10:0] off11_i;
  logic [31:0] rm_i, pc_i, lr_i, status_i;
  logic [31:0] pc_next_o, lr_val_o, swi_lr_o, swi_spsr_o, swi_status_o;
  logic        pc_load_o, lr_we_o, mode_o, swi_req_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  brmode_unit i_brmode_unit (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [31:0] v, int w);
    return ((v ^ (32'h1 << (w - 1))) - (32'h1 << (w - 1)));
  endfunction

  task automatic idle();
    valid_i = 0; kind_i = 0; cond_ok_i = 0; h_i = 0;
    off8_i = 0; off11_i = 0; rm_i = 0; pc_i = 0; lr_i = 0; status_i = 0;
  endtask

  task automatic issue(logic [2:0] k);
    @(negedge clk);
    valid_i = 1; kind_i = k;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 mode after reset", {31'b0, mode_o}, 32'h0);
  endtask

  task automatic t_short();
    pc_i = 32'h1004; off8_i = 8'hFE; cond_ok_i = 1;
    issue(3'd1);
    chk("R2 cond taken load", {31'b0, pc_load_o}, 32'h1);
    chk("R2 cond back target", pc_next_o, 32'h1004 + (sx(32'hFE, 8) << 1));
    off8_i = 8'h7F; #1;
    chk("R2 cond fwd target", pc_next_o, 32'h1102);
    chk("R2 cond no lr", {31'b0, lr_we_o}, 32'h0);
    pc_i = 32'h10004; off11_i = 11'h400; kind_i = 3'd2; #1;
    chk("R2 uncond min target", pc_next_o, 32'hF804);
    off11_i = 11'h3FF; #1;
    chk("R2 uncond max target", pc_next_o, 32'h10004 + 32'h7FE);
    settle();
  endtask

  task automatic t_cond_false();
    pc_i = 32'h2008; off8_i = 8'h10; cond_ok_i = 0;
    issue(3'd1);
    chk("R3 no load", {31'b0, pc_load_o}, 32'h0);
    chk("R3 no lr", {31'b0, lr_we_o}, 32'h0);
    chk("R3 seq address", pc_next_o, mode_o ? 32'h2006 : 32'h2004);
    settle();
  endtask

  task automatic t_bl_pair();
    pc_i = 32'h8004; off11_i = 11'h7FF; h_i = 0;
    issue(3'd3);
    chk("R4 first half lr", lr_val_o, 32'h7004);
    chk("R4 first half lr we", {31'b0, lr_we_o}, 32'h1);
    chk("R4 first half no load", {31'b0, pc_load_o}, 32'h0);
    @(negedge clk);
    pc_i = 32'h8006; lr_i = 32'h7004; off11_i = 11'h123; h_i = 1; #1;
    chk("R5 second half target", pc_next_o, 32'h724A);
    chk("R5 second half lr", lr_val_o, 32'h8005);
    chk("R5 second half load", {31'b0, pc_load_o}, 32'h1);
    @(negedge clk);
    pc_i = 32'h0050_0004; lr_i = 0; off11_i = 11'h400; h_i = 0; #1;
    chk("R10 far back partial", lr_val_o, 32'h0010_0004);
    @(negedge clk);
    pc_i = 32'h0050_0006; lr_i = 32'h0010_0004; off11_i = 11'h7FF; h_i = 1; #1;
    chk("R10 far back target", pc_next_o, 32'h0010_1002);
    settle();
  endtask

  task automatic t_bx();
    pc_i = 32'h1004; rm_i = 32'h2001;
    issue(3'd4);
    chk("R6 target even", pc_next_o, 32'h2000);
    chk("R6 no lr", {31'b0, lr_we_o}, 32'h0);
    settle();
    chk("R6 mode to compressed", {31'b0, mode_o}, 32'h1);
    pc_i = 32'h2004; rm_i = 32'h3000;
    issue(3'd4);
    chk("R6 even target", pc_next_o, 32'h3000);
    settle();
    chk("R6 mode to native", {31'b0, mode_o}, 32'h0);
  endtask

  task automatic t_blx();
    pc_i = 32'h4008; rm_i = 32'h6001;
    issue(3'd5);
    chk("R7 native lr", lr_val_o, 32'h4004);
    chk("R7 native target", pc_next_o, 32'h6000);
    settle();
    chk("R7 mode set", {31'b0, mode_o}, 32'h1);
    pc_i = 32'h4004; rm_i = 32'h5000;
    issue(3'd5);
    chk("R7 compressed lr", lr_val_o, 32'h4003);
    chk("R7 lr we", {31'b0, lr_we_o}, 32'h1);
    settle();
    chk("R7 mode cleared", {31'b0, mode_o}, 32'h0);
    pc_i = 32'h0; rm_i = 32'h1;
    issue(3'd4);
    settle();
  endtask

  task automatic t_swi();
    chk("R8 precondition compressed", {31'b0, mode_o}, 32'h1);
    pc_i = 32'h9004; status_i = 32'h0000_0030;
    issue(3'd6);
    chk("R8 req", {31'b0, swi_req_o}, 32'h1);
    chk("R8 vector", pc_next_o, 32'h8);
    chk("R8 saved lr", swi_lr_o, 32'h9002);
    chk("R8 saved status", swi_spsr_o, 32'h30);
    chk("R8 new status", swi_status_o, 32'h93);
    settle();
    chk("R8 mode cleared", {31'b0, mode_o}, 32'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    valid_i = 0; kind_i = 3'd5; rm_i = 32'h7777; pc_i = 32'h100; #1;
    chk("R9 idle no load", {31'b0, pc_load_o}, 32'h0);
    chk("R9 idle no lr", {31'b0, lr_we_o}, 32'h0);
    @(negedge clk); #1;
    chk("R9 idle mode held", {31'b0, mode_o}, 32'h0);
    valid_i = 1; kind_i = 3'd7; #1;
    chk("R9 reserved no load", {31'b0, pc_load_o | lr_we_o | swi_req_o}, 32'h0);
    @(negedge clk); #1;
    chk("R9 reserved mode held", {31'b0, mode_o}, 32'h0);
    kind_i = 3'd0; #1;
    chk("R9 none no load", {31'b0, pc_load_o | lr_we_o}, 32'h0);
    settle();
  endtask

  initial begin
    t_reset();
    t_short();
    t_cond_false();
    t_bl_pair();
    t_bx();
    t_blx();
    t_cond_false();
    t_swi();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule